// File: doc/BRIEF.md
# Deferred Condition-Code Flag Unit

This block holds the condition codes of a processor core in deferred form. It does not compute the five flags (extend X, negative N, zero Z, overflow V, carry C) when an arithmetic instruction retires. Instead it records a small operation tag, the stored result and the second operand. The flags are rebuilt from that record only when something needs them. For add and subtract, the first operand is recovered from the result and the second operand. Every operand is sign-extended to the operation size, so the flags always come from the byte, word or long part alone.

The packed flag byte is evaluated live from the pending record. The register state holds the flags as they stood at the last fold. A fold happens on a flush command, or when a new operation is recorded, which first folds the one still pending. Direct writes of the condition-code byte and of the status word place the flags in their internal forms and switch the tag to explicit-flags mode. In the internal forms, N and V are all-ones or zero words and Z is inverted: a zero word means the flag is set. An unsupported tag value raises an error output and leaves the flags untouched.

Top module: `cc_lazy_flags`

## Requirements
- R1: After reset the packed byte is 0x00, `tag_o` is 0, `err_o` is 0, `sr_o` is 0 and `z_o` is 1, which is the internal form of a clear Z.
- R2: The packed byte `ccr_o` has X in bit 4, N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Bits 7..5 are zero.
- R3: The tag values are 0 for explicit flags, 1/2/3 for add, 4/5/6 for subtract and 7/8/9 for compare, each at byte/word/long. For an add, src1 is the result minus src2. C is set when the result is unsigned-below src2, and X equals C. V is (res^src1)&~(src1^src2) at the sign bit.
- R4: For a subtract, src1 is the result plus src2. C is set when src1 is unsigned-below src2, and X equals C. V is (res^src1)&(src1^src2) at the sign bit.
- R5: For a compare, the result slot carries src1 and the result is src1 minus src2. C and V follow the subtract rules, and X keeps its stored value.
- R6: The size offset within each group selects sign extension from 8, 16 or DATA_W bits. Bits above the size never affect the flags. N is the sign bit of the result at that size, and Z is set when the result at that size is zero.
- R7: A condition-code write (`ccr_wdata_i` bits in the R2 layout) stores X and C as 0/1 and N and V as all-ones or zero. It stores Z as 0 when set and 1 when clear, and sets the tag to 0.
- R8: A status write stores `sr_wdata_i & 0xFFE0` as the status word. It loads bits 4..0 into the flags as in R7 and sets the tag to 0.
- R9: A flush stores the evaluated flags and sets the tag to 0, and the packed byte is unchanged. N and Z are stored as the sign-extended result and V as the sign-extended overflow word.
- R10: Recording an operation first folds the pending one, so a compare recorded after an add sees the add's carry as X.
- R11: A tag above 9 drives `err_o` high. The packed byte then shows the stored flags, and a flush leaves them unchanged and sets the tag to 0.
- R12: When strobes coincide, the status write takes precedence over the condition-code write. The condition-code write takes precedence over recording, and recording takes precedence over flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rec_we_i | input | 1 | Record a new deferred operation |
| rec_tag_i | input | 4 | Operation tag to record |
| rec_res_i | input | DATA_W | Result (first operand for compare) |
| rec_src_i | input | DATA_W | Second operand |
| ccr_we_i | input | 1 | Condition-code write strobe |
| ccr_wdata_i | input | 5 | Flag bits in packed layout |
| sr_we_i | input | 1 | Status word write strobe |
| sr_wdata_i | input | 16 | Status word write data |
| flush_i | input | 1 | Fold the pending tag into explicit flags |
| ccr_o | output | 8 | Live packed flag byte |
| sr_o | output | 16 | Upper status word |
| tag_o | output | 4 | Pending operation tag |
| err_o | output | 1 | Pending tag is unsupported |
| x_o | output | 1 | Stored X |
| n_o | output | DATA_W | Stored N (sign form) |
| z_o | output | DATA_W | Stored Z (zero word means set) |
| v_o | output | DATA_W | Stored V (sign form) |
| c_o | output | 1 | Stored C |

## Verification
The bench builds the block with DATA_W at its default of 32. At that width the long-size tags put the sign bit at bit 31, and the carry and overflow cases at the 32-bit boundary become reachable. The byte and word cases use operands whose upper bits hold unrelated values, which shows that sign extension cuts them off. With a 32-bit width the stored N and Z words after a flush can be compared with a fully sign-extended result.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam logic [3:0] CC_FLAGS = 4'd0;
  localparam logic [3:0] CC_ADD_B = 4'd1;
  localparam logic [3:0] CC_SUB_B = 4'd4;
  localparam logic [3:0] CC_CMP_B = 4'd7;
  localparam logic [3:0] CC_LAST  = 4'd9;
  localparam logic [15:0] SR_KEEP = 16'hFFE0;

  typedef enum logic [1:0] {K_FLAGS, K_ADD, K_SUB, K_CMP} cc_kind_e;
endpackage

// File: rtl/cc_eval.sv
module cc_eval #(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        tag_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              x_i,
  input  logic [DATA_W-1:0] n_i,
  input  logic [DATA_W-1:0] z_i,
  input  logic [DATA_W-1:0] v_i,
  input  logic              c_i,
  output logic              nx_x_o,
  output logic [DATA_W-1:0] nx_n_o,
  output logic [DATA_W-1:0] nx_z_o,
  output logic [DATA_W-1:0] nx_v_o,
  output logic              nx_c_o,
  output logic              known_o
);
  import cc_pkg::*;

  function automatic logic [DATA_W-1:0] sext(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    sext = {{(DATA_W-8){v[7]}}, v[7:0]};
      2'd1:    sext = {{(DATA_W-16){v[15]}}, v[15:0]};
      default: sext = v;
    endcase
  endfunction

  cc_kind_e          kind;
  logic [1:0]        sz;
  logic [DATA_W-1:0] r_e, s1_e, s2_e, ov;
  logic              cy;

  always_comb begin
    kind    = K_FLAGS;
    sz      = 2'd0;
    known_o = 1'b1;
    if (tag_i == CC_FLAGS) begin
      kind = K_FLAGS;
    end else if (tag_i < CC_SUB_B) begin
      kind = K_ADD;
      sz   = 2'(tag_i - CC_ADD_B);
    end else if (tag_i < CC_CMP_B) begin
      kind = K_SUB;
      sz   = 2'(tag_i - CC_SUB_B);
    end else if (tag_i <= CC_LAST) begin
      kind = K_CMP;
      sz   = 2'(tag_i - CC_CMP_B);
    end else begin
      known_o = 1'b0;
    end
  end

  always_comb begin
    s2_e = sext(src_i, sz);
    r_e  = sext(res_i, sz);
    s1_e = r_e;
    ov   = '0;
    cy   = 1'b0;
    nx_x_o = x_i;
    nx_n_o = n_i;
    nx_z_o = z_i;
    nx_v_o = v_i;
    nx_c_o = c_i;
    if (known_o) begin
      unique case (kind)
        K_ADD: begin
          s1_e = sext(res_i - src_i, sz);
          ov   = (r_e ^ s1_e) & ~(s1_e ^ s2_e);
          cy   = r_e < s2_e;
        end
        K_SUB: begin
          s1_e = sext(res_i + src_i, sz);
          ov   = (r_e ^ s1_e) & (s1_e ^ s2_e);
          cy   = s1_e < s2_e;
        end
        K_CMP: begin
          // result slot holds the first operand
          s1_e = sext(res_i, sz);
          r_e  = sext(res_i - src_i, sz);
          ov   = (r_e ^ s1_e) & (s1_e ^ s2_e);
          cy   = s1_e < s2_e;
        end
        default: ;
      endcase
      if (kind != K_FLAGS) begin
        nx_n_o = r_e;
        nx_z_o = r_e;
        nx_v_o = {DATA_W{ov[DATA_W-1]}};
        nx_c_o = cy;
        if (kind != K_CMP) nx_x_o = cy;
      end
    end
  end
endmodule

// File: rtl/cc_pack.sv
module cc_pack #(
  parameter int DATA_W = 32
) (
  input  logic              x_i,
  input  logic              n_neg_i,
  input  logic [DATA_W-1:0] z_i,
  input  logic              v_neg_i,
  input  logic              c_i,
  output logic [7:0]        ccr_o
);
  // Z internal form: zero word means flag set
  assign ccr_o = {3'b000, x_i, n_neg_i, ~|z_i, v_neg_i, c_i};
endmodule

// File: rtl/cc_state.sv
module cc_state #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_we_i,
  input  logic [3:0]        rec_tag_i,
  input  logic [DATA_W-1:0] rec_res_i,
  input  logic [DATA_W-1:0] rec_src_i,
  input  logic              ccr_we_i,
  input  logic [4:0]        ccr_wdata_i,
  input  logic              sr_we_i,
  input  logic [15:0]       sr_wdata_i,
  input  logic              flush_i,
  input  logic              nx_x_i,
  input  logic [DATA_W-1:0] nx_n_i,
  input  logic [DATA_W-1:0] nx_z_i,
  input  logic [DATA_W-1:0] nx_v_i,
  input  logic              nx_c_i,
  input  logic              known_i,
  output logic [3:0]        tag_o,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] src_o,
  output logic              x_o,
  output logic [DATA_W-1:0] n_o,
  output logic [DATA_W-1:0] z_o,
  output logic [DATA_W-1:0] v_o,
  output logic              c_o,
  output logic [15:0]       sr_o
);
  import cc_pkg::*;

  localparam logic [DATA_W-1:0] Z_CLEAR = DATA_W'(1);

  logic [10:0] sr_hi_q;
  logic [4:0]  ld;
  logic        ld_en, fold_en;

  assign ld      = sr_we_i ? sr_wdata_i[4:0] : ccr_wdata_i;
  assign ld_en   = sr_we_i | ccr_we_i;
  assign fold_en = !ld_en && (rec_we_i || flush_i);
  assign sr_o    = {sr_hi_q, 5'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_hi_q <= '0;
      tag_o   <= CC_FLAGS;
      res_o   <= '0;
      src_o   <= '0;
      x_o     <= 1'b0;
      n_o     <= '0;
      z_o     <= Z_CLEAR;
      v_o     <= '0;
      c_o     <= 1'b0;
    end else begin
      if (sr_we_i) sr_hi_q <= sr_wdata_i[15:5] & SR_KEEP[15:5];
      if (ld_en) begin
        tag_o <= CC_FLAGS;
        x_o   <= ld[4];
        n_o   <= {DATA_W{ld[3]}};
        z_o   <= ld[2] ? '0 : Z_CLEAR;
        v_o   <= {DATA_W{ld[1]}};
        c_o   <= ld[0];
      end else if (fold_en) begin
        x_o <= nx_x_i;
        n_o <= nx_n_i;
        z_o <= nx_z_i;
        v_o <= nx_v_i;
        c_o <= nx_c_i;
        if (rec_we_i) begin
          tag_o <= rec_tag_i;
          res_o <= rec_res_i;
          src_o <= rec_src_i;
        end else begin
          tag_o <= CC_FLAGS;
        end
      end
    end
  end

  p_sr_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_i |=> sr_o == ($past(sr_wdata_i) & SR_KEEP));

  p_ccr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ccr_we_i && !sr_we_i) |=> (tag_o == CC_FLAGS) && (x_o == $past(ccr_wdata_i[4]))
      && ((z_o == '0) == $past(ccr_wdata_i[2])) && (c_o == $past(ccr_wdata_i[0])));

  p_flush_tag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !rec_we_i && !ccr_we_i && !sr_we_i) |=> tag_o == CC_FLAGS);

  p_unknown_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !known_i && !rec_we_i && !ccr_we_i && !sr_we_i)
      |=> $stable(x_o) && $stable(c_o) && $stable(n_o) && $stable(z_o) && $stable(v_o));

  p_cmp_keeps_x_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_o >= CC_CMP_B && tag_o <= CC_LAST) |-> nx_x_i == x_o);

  p_record_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_we_i && !ccr_we_i && !sr_we_i) |=> tag_o == $past(rec_tag_i));
endmodule

// File: rtl/cc_lazy_flags.sv
module cc_lazy_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rec_we_i,
  input  logic [3:0]        rec_tag_i,
  input  logic [DATA_W-1:0] rec_res_i,
  input  logic [DATA_W-1:0] rec_src_i,
  input  logic              ccr_we_i,
  input  logic [4:0]        ccr_wdata_i,
  input  logic              sr_we_i,
  input  logic [15:0]       sr_wdata_i,
  input  logic              flush_i,
  output logic [7:0]        ccr_o,
  output logic [15:0]       sr_o,
  output logic [3:0]        tag_o,
  output logic              err_o,
  output logic              x_o,
  output logic [DATA_W-1:0] n_o,
  output logic [DATA_W-1:0] z_o,
  output logic [DATA_W-1:0] v_o,
  output logic              c_o
);
  logic [DATA_W-1:0] res_q, src_q, nx_n, nx_z, nx_v;
  logic              nx_x, nx_c, known;

  cc_state #(.DATA_W(DATA_W)) u_state (
    .clk_i, .rst_ni, .rec_we_i, .rec_tag_i, .rec_res_i, .rec_src_i,
    .ccr_we_i, .ccr_wdata_i, .sr_we_i, .sr_wdata_i, .flush_i,
    .nx_x_i(nx_x), .nx_n_i(nx_n), .nx_z_i(nx_z), .nx_v_i(nx_v), .nx_c_i(nx_c),
    .known_i(known),
    .tag_o, .res_o(res_q), .src_o(src_q),
    .x_o, .n_o, .z_o, .v_o, .c_o, .sr_o
  );

  cc_eval #(.DATA_W(DATA_W)) u_eval (
    .tag_i(tag_o), .res_i(res_q), .src_i(src_q),
    .x_i(x_o), .n_i(n_o), .z_i(z_o), .v_i(v_o), .c_i(c_o),
    .nx_x_o(nx_x), .nx_n_o(nx_n), .nx_z_o(nx_z), .nx_v_o(nx_v), .nx_c_o(nx_c),
    .known_o(known)
  );

  cc_pack #(.DATA_W(DATA_W)) u_pack (
    .x_i(nx_x), .n_neg_i(nx_n[DATA_W-1]), .z_i(nx_z),
    .v_neg_i(nx_v[DATA_W-1]), .c_i(nx_c), .ccr_o
  );

  assign err_o = ~known;
endmodule

// File: tb/cc_lazy_flags_tb_top.sv
module cc_lazy_flags_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rec_we = 1'b0, ccr_we = 1'b0, sr_we = 1'b0, flush = 1'b0;
  logic [3:0]   rec_tag = '0;
  logic [W-1:0] rec_res = '0, rec_src = '0;
  logic [4:0]   ccr_wd = '0;
  logic [15:0]  sr_wd = '0;
  logic [7:0]   ccr;
  logic [15:0]  sr;
  logic [3:0]   tag;
  logic         err, xo, co;
  logic [W-1:0] no, zo, vo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cc_lazy_flags #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rec_we_i(rec_we), .rec_tag_i(rec_tag),
    .rec_res_i(rec_res), .rec_src_i(rec_src), .ccr_we_i(ccr_we), .ccr_wdata_i(ccr_wd),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wd), .flush_i(flush),
    .ccr_o(ccr), .sr_o(sr), .tag_o(tag), .err_o(err),
    .x_o(xo), .n_o(no), .z_o(zo), .v_o(vo), .c_o(co)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference flag byte built from masked-width arithmetic
  function automatic logic [7:0] mdl(input logic [3:0] t, input logic [31:0] a,
                                     input logic [31:0] b, input logic xin);
    int k = (int'(t) - 1) / 3;
    int s = (int'(t) - 1) % 3;
    int w = (s == 0) ? 8 : (s == 1) ? 16 : 32;
    logic [31:0] m   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic [31:0] top = 32'd1 << (w - 1);
    logic [31:0] r, s1;
    logic x, n, z, v, c;
    if (k == 0) begin
      r = a & m; s1 = (a - b) & m; c = r < (b & m);
      v = ((s1 & top) == (b & top)) && ((r & top) != (s1 & top)); x = c;
    end else if (k == 1) begin
      r = a & m; s1 = (a + b) & m; c = s1 < (b & m);
      v = ((s1 & top) != (b & top)) && ((r & top) != (s1 & top)); x = c;
    end else begin
      s1 = a & m; r = (a - b) & m; c = s1 < (b & m);
      v = ((s1 & top) != (b & top)) && ((r & top) != (s1 & top)); x = xin;
    end
    n = (r & top) != 0;
    z = (r == 0);
    return {3'b0, x, n, z, v, c};
  endfunction

  task automatic pulse_done;
    @(negedge clk);
    rec_we = 0; ccr_we = 0; sr_we = 0; flush = 0;
  endtask

  task automatic do_rec(input logic [3:0] t, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    rec_we = 1; rec_tag = t; rec_res = a; rec_src = b;
    pulse_done();
  endtask

  task automatic do_ccr(input logic [4:0] d);
    @(negedge clk);
    ccr_we = 1; ccr_wd = d;
    pulse_done();
  endtask

  task automatic do_flush;
    @(negedge clk);
    flush = 1;
    pulse_done();
  endtask

  task automatic t_reset;
    chk("R1 ccr", 32'(ccr), 32'h00);
    chk("R1 tag", 32'(tag), 32'h0);
    chk("R1 err", 32'(err), 32'h0);
    chk("R1 sr", 32'(sr), 32'h0);
    chk("R1 z", zo, 32'h1);
  endtask

  task automatic t_add;
    do_rec(4'd3, 32'h0, 32'h1);
    chk("R3 add long carry zero", 32'(ccr), 32'h15);
    chk("R3 add long model", 32'(ccr), 32'(mdl(4'd3, 32'h0, 32'h1, 1'b0)));
    do_rec(4'd1, 32'h1234_5680, 32'h1);
    chk("R3 add byte overflow", 32'(ccr), 32'h0A);
    do_rec(4'd3, 32'h8000_0000, 32'h8000_0000);
    chk("R3 add long both", 32'(ccr), 32'(mdl(4'd3, 32'h8000_0000, 32'h8000_0000, 1'b0)));
  endtask

  task automatic t_size;
    do_rec(4'd1, 32'hFFFF_FF80, 32'h1);
    chk("R6 byte ignores upper", 32'(ccr), 32'h0A);
    do_rec(4'd2, 32'hABCD_0000, 32'h5555_0001);
    chk("R6 word", 32'(ccr), 32'(mdl(4'd2, 32'hABCD_0000, 32'h5555_0001, 1'b0)));
    do_rec(4'd8, 32'h1234_0005, 32'h9999_0005);
    chk("R6 cmp word zero", 32'(ccr) & 32'h0F, 32'h04);
  endtask

  task automatic t_sub;
    do_rec(4'd5, 32'h0000_FFFF, 32'h1);
    chk("R4 sub word", 32'(ccr), 32'h19);
    do_rec(4'd6, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    chk("R4 sub long model", 32'(ccr), 32'(mdl(4'd6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0)));
  endtask

  task automatic t_cmp;
    do_ccr(5'h10);
    do_rec(4'd9, 32'h5, 32'h5);
    chk("R5 cmp equal keeps X", 32'(ccr), 32'h14);
    do_ccr(5'h00);
    do_rec(4'd7, 32'hAB80, 32'h01);
    chk("R5 cmp byte", 32'(ccr), 32'(mdl(4'd7, 32'hAB80, 32'h01, 1'b0)));
    chk("R5 cmp byte V", 32'(ccr[1]), 32'h1);
  endtask

  task automatic t_ccr;
    do_ccr(5'h0A);
    chk("R7 ccr byte", 32'(ccr), 32'h0A);
    chk("R7 n form", no, 32'hFFFF_FFFF);
    chk("R7 v form", vo, 32'hFFFF_FFFF);
    chk("R7 z clear form", zo, 32'h1);
    chk("R7 tag", 32'(tag), 32'h0);
    do_ccr(5'h15);
    chk("R7 z set form", zo, 32'h0);
    chk("R2 layout", 32'({xo, co}), 32'h3);
  endtask

  task automatic t_sr;
    @(negedge clk);
    sr_we = 1; sr_wd = 16'h27FF;
    pulse_done();
    chk("R8 sr mask", 32'(sr), 32'h27E0);
    chk("R8 sr flags", 32'(ccr), 32'h1F);
    chk("R8 n form", no, 32'hFFFF_FFFF);
  endtask

  task automatic t_flush;
    do_rec(4'd1, 32'h1234_5680, 32'h1);
    do_flush();
    chk("R9 tag", 32'(tag), 32'h0);
    chk("R9 ccr kept", 32'(ccr), 32'h0A);
    chk("R9 n raw", no, 32'hFFFF_FF80);
    chk("R9 z raw", zo, 32'hFFFF_FF80);
    chk("R9 x", 32'(xo), 32'h0);
  endtask

  task automatic t_fold;
    do_ccr(5'h00);
    do_rec(4'd3, 32'h0, 32'h1);
    do_rec(4'd9, 32'h3, 32'h1);
    chk("R10 folded x", 32'(xo), 32'h1);
    chk("R10 cmp sees carry", 32'(ccr), 32'h10);
  endtask

  task automatic t_unknown;
    do_ccr(5'h05);
    do_rec(4'd12, 32'h0, 32'h0);
    chk("R11 err", 32'(err), 32'h1);
    chk("R11 ccr held", 32'(ccr), 32'h05);
    do_flush();
    chk("R11 tag", 32'(tag), 32'h0);
    chk("R11 err clear", 32'(err), 32'h0);
    chk("R11 flags held", 32'(ccr), 32'h05);
  endtask

  task automatic t_priority;
    @(negedge clk);
    sr_we = 1; sr_wd = 16'h0013; ccr_we = 1; ccr_wd = 5'h0C;
    pulse_done();
    chk("R12 sr over ccr", 32'(ccr), 32'h13);
    @(negedge clk);
    rec_we = 1; rec_tag = 4'd3; rec_res = 32'h0; rec_src = 32'h1; flush = 1;
    pulse_done();
    chk("R12 rec over flush", 32'(tag), 32'h3);
    @(negedge clk);
    rec_we = 1; rec_tag = 4'd6; ccr_we = 1; ccr_wd = 5'h02;
    pulse_done();
    chk("R12 ccr over rec tag", 32'(tag), 32'h0);
    chk("R12 ccr over rec flags", 32'(ccr), 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_size();
    t_sub();
    t_cmp();
    t_ccr();
    t_sr();
    t_flush();
    t_fold();
    t_unknown();
    t_priority();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule